// File: doc/BRIEF.md
# Reuse-distance block replacement engine

This block decides replacement for a small fully associative cache of block numbers. The cache has `PROT_SLOTS` protected entries and `PROB_SLOTS` probation entries. Protected entries are blocks whose reuse distance has proven short. Probation entries are resident blocks still on trial, and only they can be evicted. A bounded history stack orders blocks by recency. It holds every protected block, some probation blocks, and ghost entries for blocks that were evicted but are still remembered. A separate LRU queue orders the resident probation blocks.

Each reference is a block number presented with `refValid` while `busy` is low. A fixed number of cycles later the engine pulses `respValid` and reports two things: whether the block was resident, and, on a miss, which resident block was displaced. A probation or ghost block that is referenced while it is still in the history stack is promoted to protected. In exchange, the protected block at the stack bottom is demoted, so no recency comparisons are needed. The engine keeps no data. The caller moves the data using the reported victim.

Top module: `rdr_engine`

## Requirements
- R1: A reference accepted on a rising edge with `busy` low raises `busy` on the next cycle. `respValid` pulses for exactly one cycle, 6 cycles after acceptance, with `busy` low. A `refValid` asserted while `busy` is high is ignored.
- R2: After reset the cache is empty and `busy`, `respValid`, `hit` and `evictValid` are 0.
- R3: While fewer than `PROT_SLOTS` blocks are protected, a reference to a new block misses without eviction and the block becomes protected. Once the protected set is full it stays full.
- R4: A reference to a protected block reports a hit with no eviction and moves the block to the top of the history stack.
- R5: Once the protected set is full, a new block that misses while the probation queue has a free slot misses without eviction. It enters the stack top and the queue's most recent end as probation.
- R6: A miss with a full cache evicts the least recently used probation block, reported on `evictBlock` with `evictValid` high. A protected block and the referenced block are never evicted, and a hit never evicts.
- R7: A hit on a probation block that is still in the history stack promotes it to protected at the stack top. The bottom protected block is removed from the stack and becomes probation at the queue's most recent end.
- R8: A hit on a probation block that is not in the history stack keeps it probation and moves it to the stack top and to the queue's most recent end.
- R9: After every reference, the stack bottom holds a protected block: non-protected entries below the deepest protected entry are discarded. A later reference to a discarded block behaves as a block not in the stack.
- R10: When a push would exceed `HIST_DEPTH` entries, the deepest ghost entry is dropped first.
- R11: An evicted block that is still in the stack stays there as a ghost. A later miss on that block promotes it to protected, with the same demotion as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | Reference request, taken when `busy` is low |
| refBlock | input | BLOCK_W | Referenced block number |
| busy | output | 1 | High while a reference is being processed |
| respValid | output | 1 | One-cycle pulse marking a valid result |
| hit | output | 1 | Referenced block was resident |
| evictValid | output | 1 | A resident block was displaced |
| evictBlock | output | BLOCK_W | Displaced block number, 0 when none |

## Verification
The bench runs long reference streams against an arithmetic model of the policy. The streams are a tiny hot set, a wide alphabet that overflows the history stack, a cyclic loop one longer than the cache, and a one-shot scan mixed with hot blocks. Each one targets a corner of the policy. An engine that picked its victim from the wrong end of the probation queue, or evicted a protected block, would report the wrong `evictBlock`. One that skipped the bottom pruning would later promote a block it should treat as new, and show a wrong hit or victim. One that dropped the newest ghost instead of the deepest on overflow, or forgot to keep evicted blocks as ghosts, would diverge on the following reference to that block. Requests asserted mid-operation check that the engine does not absorb a second reference while busy.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

  // Per-entry state of the history stack
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_PROT  = 2'd1,
    ST_PROB  = 2'd2,
    ST_GHOST = 2'd3
  } entState_t;

  // Action decided in the lookup phase
  typedef enum logic [2:0] {
    K_PROT_HIT,
    K_PROB_PROMOTE,
    K_PROB_REFRESH,
    K_WARM,
    K_GHOST_PROMOTE,
    K_MISS_NEW
  } refKind_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;
    logic sPush;
    logic sPushProt;
    logic sMoveMatch;
    logic sMarkGhost;
    logic sDropBottom;
    logic sPrune;
    logic qEvict;
    logic qPush;
    logic qPushDemoted;
    logic qRemoveMatch;
  } rdrStrobe_t;

  // Datapath-to-control lookup flags for the captured block
  typedef struct packed {
    logic sHit;
    logic sIsProt;
    logic qHit;
    logic qFull;
    logic protFull;
  } rdrFlags_t;

endpackage

// File: rtl/rdr_datapath.sv
module rdr_datapath
  import rdr_pkg::*;
#(
  parameter int BLOCK_W    = 8,
  parameter int PROT_SLOTS = 3,
  parameter int PROB_SLOTS = 2,
  parameter int HIST_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  rdrStrobe_t         stb,
  input  logic [BLOCK_W-1:0] refBlockIn,
  output rdrFlags_t          flags,
  output logic [BLOCK_W-1:0] lruBlk
);

  localparam int SIW = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1;
  localparam int QIW = (PROB_SLOTS > 1) ? $clog2(PROB_SLOTS) : 1;
  localparam int CW  = $clog2(HIST_DEPTH + 1);

  logic [BLOCK_W-1:0] refBlk;
  logic [BLOCK_W-1:0] sBlk [HIST_DEPTH];
  entState_t          sSt  [HIST_DEPTH];
  logic [BLOCK_W-1:0] qBlk [PROB_SLOTS];
  logic [PROB_SLOTS-1:0] qV;

  logic [BLOCK_W-1:0] nsBlk [HIST_DEPTH];
  entState_t          nsSt  [HIST_DEPTH];
  logic [BLOCK_W-1:0] nqBlk [PROB_SLOTS];
  logic [PROB_SLOTS-1:0] nqV;

  // Stack lookup
  logic sHit, sIsProt, sFull, anyProt;
  logic [SIW-1:0] sIdx, ghostIdx, botIdx, rIdx;
  logic [CW-1:0]  protCnt;
  logic [HIST_DEPTH-1:0] keep;

  always_comb begin
    sHit     = 1'b0;
    sIsProt  = 1'b0;
    sIdx     = '0;
    ghostIdx = '0;
    botIdx   = '0;
    protCnt  = '0;
    anyProt  = 1'b0;
    for (int i = 0; i < HIST_DEPTH; i++) begin
      if (sSt[i] != ST_EMPTY) begin
        botIdx = SIW'(i);
        if (sBlk[i] == refBlk) begin
          sHit    = 1'b1;
          sIdx    = SIW'(i);
          sIsProt = (sSt[i] == ST_PROT);
        end
      end
      if (sSt[i] == ST_GHOST) ghostIdx = SIW'(i);
      if (sSt[i] == ST_PROT)  protCnt  = protCnt + CW'(1);
    end
    for (int i = HIST_DEPTH - 1; i >= 0; i--) begin
      anyProt = anyProt | (sSt[i] == ST_PROT);
      keep[i] = anyProt;
    end
  end

  assign sFull = (sSt[HIST_DEPTH-1] != ST_EMPTY);
  // Slot vacated by a push: the moved entry, the deepest ghost on overflow, else the empty tail
  assign rIdx  = stb.sMoveMatch ? sIdx : (sFull ? ghostIdx : SIW'(HIST_DEPTH - 1));

  // Queue lookup
  logic qHit;
  logic [QIW-1:0] qIdx, qRem;

  always_comb begin
    qHit = 1'b0;
    qIdx = '0;
    for (int i = 0; i < PROB_SLOTS; i++) begin
      if (qV[i] && qBlk[i] == refBlk) begin
        qHit = 1'b1;
        qIdx = QIW'(i);
      end
    end
  end

  assign lruBlk = qBlk[PROB_SLOTS-1];
  assign qRem   = stb.qRemoveMatch ? qIdx : QIW'(PROB_SLOTS - 1);

  assign flags.sHit     = sHit;
  assign flags.sIsProt  = sIsProt;
  assign flags.qHit     = qHit;
  assign flags.qFull    = qV[PROB_SLOTS-1];
  assign flags.protFull = (protCnt >= CW'(PROT_SLOTS));

  // Stack next state
  always_comb begin
    for (int i = 0; i < HIST_DEPTH; i++) begin
      nsBlk[i] = sBlk[i];
      nsSt[i]  = sSt[i];
    end
    if (stb.sMarkGhost) begin
      for (int i = 0; i < HIST_DEPTH; i++) begin
        if (sSt[i] != ST_EMPTY && sBlk[i] == lruBlk) nsSt[i] = ST_GHOST;
      end
    end
    if (stb.sPush) begin
      for (int i = 1; i < HIST_DEPTH; i++) begin
        if (i <= int'(rIdx)) begin
          nsBlk[i] = sBlk[i-1];
          nsSt[i]  = sSt[i-1];
        end
      end
      nsBlk[0] = refBlk;
      nsSt[0]  = stb.sPushProt ? ST_PROT : ST_PROB;
    end
    if (stb.sDropBottom) begin
      for (int i = 0; i < HIST_DEPTH; i++) begin
        if (i == int'(botIdx)) nsSt[i] = ST_EMPTY;
      end
    end
    if (stb.sPrune) begin
      for (int i = 0; i < HIST_DEPTH; i++) begin
        if (!keep[i]) nsSt[i] = ST_EMPTY;
      end
    end
  end

  // Queue next state
  always_comb begin
    for (int i = 0; i < PROB_SLOTS; i++) nqBlk[i] = qBlk[i];
    nqV = qV;
    if (stb.qEvict) nqV[PROB_SLOTS-1] = 1'b0;
    if (stb.qRemoveMatch && !stb.qPush) begin
      for (int i = 0; i < PROB_SLOTS; i++) begin
        if (i >= int'(qIdx)) begin
          if (i < PROB_SLOTS - 1) begin
            nqBlk[i] = qBlk[i+1];
            nqV[i]   = qV[i+1];
          end else begin
            nqV[i] = 1'b0;
          end
        end
      end
    end
    if (stb.qPush) begin
      for (int i = 1; i < PROB_SLOTS; i++) begin
        if (i <= int'(qRem)) begin
          nqBlk[i] = qBlk[i-1];
          nqV[i]   = qV[i-1];
        end
      end
      nqBlk[0] = stb.qPushDemoted ? sBlk[botIdx] : refBlk;
      nqV[0]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refBlk <= '0;
      qV     <= '0;
      for (int i = 0; i < HIST_DEPTH; i++) begin
        sBlk[i] <= '0;
        sSt[i]  <= ST_EMPTY;
      end
      for (int i = 0; i < PROB_SLOTS; i++) qBlk[i] <= '0;
    end else begin
      if (stb.capture) refBlk <= refBlockIn;
      qV <= nqV;
      for (int i = 0; i < HIST_DEPTH; i++) begin
        sBlk[i] <= nsBlk[i];
        sSt[i]  <= nsSt[i];
      end
      for (int i = 0; i < PROB_SLOTS; i++) qBlk[i] <= nqBlk[i];
    end
  end

endmodule

// File: rtl/rdr_control.sv
module rdr_control
  import rdr_pkg::*;
#(
  parameter int BLOCK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refValid,
  input  rdrFlags_t          flags,
  input  logic [BLOCK_W-1:0] lruBlk,
  output rdrStrobe_t         stb,
  output logic               busy,
  output logic               respValid,
  output logic               hit,
  output logic               evictValid,
  output logic [BLOCK_W-1:0] evictBlock
);

  typedef enum logic [2:0] {
    PH_IDLE, PH_LOOK, PH_EVICT, PH_MOVE, PH_DEMOTE, PH_PRUNE
  } phase_t;

  phase_t   phase, phaseNext;
  refKind_t kind, lookKind;
  logic     pendHit, pendEvict, lookHit;
  logic [BLOCK_W-1:0] pendBlk;
  logic     promoteKind;

  assign busy        = (phase != PH_IDLE);
  assign promoteKind = (kind == K_PROB_PROMOTE) || (kind == K_GHOST_PROMOTE);

  // Classify the captured reference
  always_comb begin
    lookHit = (flags.sHit && flags.sIsProt) || flags.qHit;
    if (flags.sHit && flags.sIsProt)  lookKind = K_PROT_HIT;
    else if (flags.qHit)              lookKind = flags.sHit ? K_PROB_PROMOTE : K_PROB_REFRESH;
    else if (!flags.protFull)         lookKind = K_WARM;
    else if (flags.sHit)              lookKind = K_GHOST_PROMOTE;
    else                              lookKind = K_MISS_NEW;
  end

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (refValid) begin
          stb.capture = 1'b1;
          phaseNext   = PH_LOOK;
        end
      end
      PH_LOOK: phaseNext = PH_EVICT;
      PH_EVICT: begin
        if (pendEvict) begin
          stb.qEvict     = 1'b1;
          stb.sMarkGhost = 1'b1;
        end
        phaseNext = PH_MOVE;
      end
      PH_MOVE: begin
        stb.sPush = 1'b1;
        unique case (kind)
          K_PROT_HIT: begin
            stb.sPushProt  = 1'b1;
            stb.sMoveMatch = 1'b1;
          end
          K_PROB_PROMOTE: begin
            stb.sPushProt    = 1'b1;
            stb.sMoveMatch   = 1'b1;
            stb.qRemoveMatch = 1'b1;
          end
          K_GHOST_PROMOTE: begin
            stb.sPushProt  = 1'b1;
            stb.sMoveMatch = 1'b1;
          end
          K_PROB_REFRESH: begin
            stb.qRemoveMatch = 1'b1;
            stb.qPush        = 1'b1;
          end
          K_MISS_NEW: stb.qPush = 1'b1;
          default:    stb.sPushProt = 1'b1;
        endcase
        phaseNext = PH_DEMOTE;
      end
      PH_DEMOTE: begin
        if (promoteKind) begin
          stb.sDropBottom  = 1'b1;
          stb.qPush        = 1'b1;
          stb.qPushDemoted = 1'b1;
        end
        phaseNext = PH_PRUNE;
      end
      default: begin
        stb.sPrune = 1'b1;
        phaseNext  = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      kind       <= K_WARM;
      pendHit    <= 1'b0;
      pendEvict  <= 1'b0;
      pendBlk    <= '0;
      respValid  <= 1'b0;
      hit        <= 1'b0;
      evictValid <= 1'b0;
      evictBlock <= '0;
    end else begin
      phase     <= phaseNext;
      respValid <= 1'b0;
      if (phase == PH_LOOK) begin
        kind      <= lookKind;
        pendHit   <= lookHit;
        pendEvict <= !lookHit && flags.protFull && flags.qFull;
      end
      if (phase == PH_EVICT && pendEvict) pendBlk <= lruBlk;
      if (phase == PH_PRUNE) begin
        respValid  <= 1'b1;
        hit        <= pendHit;
        evictValid <= pendEvict;
        evictBlock <= pendEvict ? pendBlk : '0;
      end
    end
  end

endmodule

// File: rtl/rdr_engine.sv
module rdr_engine
  import rdr_pkg::*;
#(
  parameter int BLOCK_W    = 8,
  parameter int PROT_SLOTS = 3,
  parameter int PROB_SLOTS = 2,
  parameter int HIST_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refValid,
  input  logic [BLOCK_W-1:0] refBlock,
  output logic               busy,
  output logic               respValid,
  output logic               hit,
  output logic               evictValid,
  output logic [BLOCK_W-1:0] evictBlock
);

  rdrStrobe_t         stb;
  rdrFlags_t          dpFlags;
  logic [BLOCK_W-1:0] lruBlk;

  rdr_control #(.BLOCK_W(BLOCK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .refValid(refValid), .flags(dpFlags),
    .lruBlk(lruBlk), .stb(stb), .busy(busy), .respValid(respValid),
    .hit(hit), .evictValid(evictValid), .evictBlock(evictBlock)
  );

  rdr_datapath #(
    .BLOCK_W(BLOCK_W), .PROT_SLOTS(PROT_SLOTS),
    .PROB_SLOTS(PROB_SLOTS), .HIST_DEPTH(HIST_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .refBlockIn(refBlock),
    .flags(dpFlags), .lruBlk(lruBlk)
  );

endmodule

// File: rtl/rdr_engine_checker.sv
module rdr_engine_checker #(
  parameter int BLOCK_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               refValid,
  input logic [BLOCK_W-1:0] refBlock,
  input logic               busy,
  input logic               respValid,
  input logic               hit,
  input logic               evictValid,
  input logic [BLOCK_W-1:0] evictBlock,
  input logic               protFull
);

  logic               accept;
  logic [BLOCK_W-1:0] heldRef;

  assign accept = refValid && !busy;

  always_ff @(posedge clk) begin
    if (!rstN)       heldRef <= '0;
    else if (accept) heldRef <= refBlock;
  end

  p_fixed_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> ##6 respValid);

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> busy);

  p_resp_when_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !busy);

  p_no_evict_on_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && hit) |-> !evictValid);

  p_victim_not_ref_r6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && evictValid) |-> (evictBlock != heldRef));

  p_evict_after_warm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && evictValid) |-> protFull);

  p_prot_full_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    protFull |=> protFull);

endmodule

bind rdr_engine rdr_engine_checker #(.BLOCK_W(BLOCK_W)) u_check (
  .clk(clk), .rstN(rstN), .refValid(refValid), .refBlock(refBlock),
  .busy(busy), .respValid(respValid), .hit(hit), .evictValid(evictValid),
  .evictBlock(evictBlock), .protFull(dpFlags.protFull)
);

// File: tb/rdr_engine_test.sv
module rdr_engine_test;

  localparam int BW = 8;
  localparam int PS = 3;
  localparam int QS = 2;
  localparam int HD = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          refValid = 1'b0;
  logic [BW-1:0] refBlock = '0;
  logic          busy, respValid, hit, evictValid;
  logic [BW-1:0] evictBlock;

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rdr_engine #(.BLOCK_W(BW), .PROT_SLOTS(PS), .PROB_SLOTS(QS), .HIST_DEPTH(HD)) uut (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refBlock(refBlock),
    .busy(busy), .respValid(respValid), .hit(hit),
    .evictValid(evictValid), .evictBlock(evictBlock)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Policy model: 1 protected, 2 probation, 3 ghost; index 0 is most recent
  int mSb [HD];
  int mSs [HD];
  int mSn = 0;
  int mQb [QS];
  int mQn = 0;
  int mProt = 0;

  task automatic mRemove(input int i);
    for (int j = i; j < mSn - 1; j++) begin
      mSb[j] = mSb[j+1];
      mSs[j] = mSs[j+1];
    end
    mSn--;
  endtask

  task automatic mPush(input int b, input int st, inout bit ovf);
    if (mSn == HD) begin
      int k;
      k = 0;
      for (int j = 0; j < HD; j++) if (mSs[j] == 3) k = j;
      mRemove(k);
      ovf = 1'b1;
    end
    for (int j = mSn; j > 0; j--) begin
      mSb[j] = mSb[j-1];
      mSs[j] = mSs[j-1];
    end
    mSb[0] = b;
    mSs[0] = st;
    mSn++;
  endtask

  task automatic mQPush(input int b);
    for (int j = mQn; j > 0; j--) if (j < QS) mQb[j] = mQb[j-1];
    mQb[0] = b;
    mQn++;
  endtask

  task automatic mQRemove(input int i);
    for (int j = i; j < mQn - 1; j++) mQb[j] = mQb[j+1];
    mQn--;
  endtask

  task automatic mDemote();
    int bb;
    bb = mSb[mSn-1];
    mSn--;
    mQPush(bb);
  endtask

  task automatic model(input int b, output bit eh, output bit ev, output int eb, output string tag);
    int si, qi;
    bit ovf, pr;
    si = -1; qi = -1; ovf = 1'b0; pr = 1'b0;
    eh = 1'b0; ev = 1'b0; eb = 0; tag = "R5";
    for (int j = 0; j < mSn; j++) if (mSb[j] == b) si = j;
    for (int j = 0; j < mQn; j++) if (mQb[j] == b) qi = j;
    if (si >= 0 && mSs[si] == 1) begin
      eh = 1'b1; tag = "R4";
      mRemove(si); mPush(b, 1, ovf);
    end else if (qi >= 0) begin
      eh = 1'b1;
      mQRemove(qi);
      if (si >= 0) begin
        tag = "R7"; mRemove(si); mPush(b, 1, ovf); mDemote();
      end else begin
        tag = "R8"; mPush(b, 2, ovf); mQPush(b);
      end
    end else if (mProt < PS) begin
      tag = "R3"; mPush(b, 1, ovf); mProt++;
    end else begin
      if (mQn == QS) begin
        ev = 1'b1; eb = mQb[QS-1]; mQn--; tag = "R6";
        for (int j = 0; j < mSn; j++) if (mSb[j] == eb) mSs[j] = 3;
      end
      if (si >= 0) begin
        tag = "R11"; mRemove(si); mPush(b, 1, ovf); mDemote();
      end else begin
        mPush(b, 2, ovf); mQPush(b);
      end
    end
    while (mSn > 0 && mSs[mSn-1] != 1) begin
      mSn--; pr = 1'b1;
    end
    if (pr)  tag = "R9";
    if (ovf) tag = "R10";
  endtask

  task automatic doRef(input int b, input bit poke);
    bit eh, ev;
    int eb, k;
    bit got;
    string tag;
    model(b, eh, ev, eb, tag);
    @(negedge clk);
    check(respValid == 1'b0, "R1", "respValid pulse width", int'(respValid), 0);
    check(busy == 1'b0, "R1", "busy before request", int'(busy), 0);
    refValid = 1'b1;
    refBlock = BW'(b);
    got = 1'b0;
    k = 0;
    while (!got && k < 12) begin
      @(negedge clk);
      k++;
      if (k == 1) refValid = 1'b0;
      if (poke && k == 2) begin
        refValid = 1'b1;
        refBlock = BW'(b + 1);
      end
      if (poke && k == 3) refValid = 1'b0;
      if (respValid) got = 1'b1;
    end
    check(k == 6, "R1", "response latency", k, 6);
    check(busy == 1'b0, "R1", "busy at response", int'(busy), 0);
    check(hit == eh, tag, "hit", int'(hit), int'(eh));
    check(evictValid == ev, tag, "evictValid", int'(evictValid), int'(ev));
    if (ev) check(int'(evictBlock) == eb, tag, "evictBlock", int'(evictBlock), eb);
  endtask

  int seed = 12345;
  function automatic int nextRand(input int alpha);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffff) % alpha;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R2: idle and empty out of reset
    check(busy == 1'b0, "R2", "busy in reset", int'(busy), 0);
    check(respValid == 1'b0, "R2", "respValid in reset", int'(respValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R2", "busy after reset", int'(busy), 0);
    check(respValid == 1'b0, "R2", "respValid after reset", int'(respValid), 0);
    check(hit == 1'b0, "R2", "hit after reset", int'(hit), 0);
    check(evictValid == 1'b0, "R2", "evictValid after reset", int'(evictValid), 0);

    // Directed opening: warm-up, protected hit, probation fill, eviction, ghost promotion
    doRef(1, 1'b0); doRef(2, 1'b0); doRef(3, 1'b0);
    doRef(1, 1'b0); doRef(4, 1'b0); doRef(5, 1'b0);
    doRef(6, 1'b0); doRef(4, 1'b0); doRef(5, 1'b0);
    doRef(3, 1'b0); doRef(2, 1'b0);

    // Small hot set
    for (int n = 0; n < 300; n++) doRef(nextRand(6), (n % 7) == 3);
    // Wide alphabet that overflows the history stack
    for (int n = 0; n < 600; n++) doRef(nextRand(24), (n % 11) == 5);
    // Cyclic loop one longer than the cache
    for (int p = 0; p < 20; p++)
      for (int j = 0; j < PS + QS + 1; j++) doRef(40 + j, 1'b0);
    // One-shot scan mixed with hot blocks
    for (int n = 0; n < 100; n++) begin
      doRef(100 + n, 1'b0);
      if ((n % 3) == 0) doRef(60 + nextRand(3), 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule